// File: doc/BRIEF.md
# Dual-Rate Digital Phase Tracking Loop

This block is a digital phase-tracking loop that runs at two rates. On every fast clock cycle it computes the error between an incoming phase sample and its own reference phase. That error passes through a selectable detector law, either a sawtooth or a sine, and the result is added into an integrate-and-dump accumulator. After a programmable number of fast cycles the accumulator dumps its sum as one error sample and clears. Only then do the loop filter and the phase controller move.

The filter is first order with a constant gain. The gain is a power of two and is applied as an arithmetic right shift. The controller has two modes. In epoch mode it is a summer: the filter output is added straight to the reference phase. In carrier mode the filter output is treated as a frequency word, and the phase advances by half the sum of the current and previous frequency words, which is the trapezoidal rule. Phases are 16-bit two's-complement words in which full scale spans -π to +π, so all phase arithmetic wraps modulo 2π.

Top module: `dpll_dual_rate`

## Requirements
- R1: While reset is asserted and right after it is released, `ref_phase` is 0, `err_sample` is 0 and `dump_stb` is 0.
- R2: The phase error on each fast cycle is `phase_in - ref_phase`, taken modulo 2^16. With `sine_law`=0 the detector output is that error read as a signed 16-bit value.
- R3: With `sine_law`=1 the detector output is a sine value. Error bits [15:14] select the quadrant and bits [13:8] give k. The index is k in quadrants 0 and 2, and 64-k in quadrants 1 and 3. The table value is T(i) = floor(32767*4*p / (5*4096 - p)), where p = i*(128-i). The value is negated in quadrants 2 and 3.
- R4: The update length L is captured from `upd_len` while reset is asserted, and a value of 0 acts as 1. Every L fast cycles, `err_sample` takes the sum of the last L detector outputs. `dump_stb` is high for exactly the one cycle in which that new sum first appears, and `err_sample` holds its value between dumps.
- R5: `ref_phase` changes only on the clock edge that follows a cycle with `dump_stb` high. The detector sample taken on that same edge still uses the old reference.
- R6: The filter output y is `err_sample` arithmetically shifted right by `gain_shift` bits (0 to 15).
- R7: With `carrier_mode`=0, each update adds the low 16 bits of y to `ref_phase`. Under a constant input phase and a loop gain below one, the reference settles on that input.
- R8: With `carrier_mode`=1, each update adds bits [16:1] of the 33-bit sum y + y_prev to `ref_phase`. Here y_prev is the filter output of the previous update, and it is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sine_law | input | 1 | Detector law: 0 sawtooth, 1 sine |
| carrier_mode | input | 1 | Controller: 0 epoch summer, 1 trapezoidal carrier integrator |
| gain_shift | input | 4 | Filter gain as a right shift |
| upd_len | input | 16 | Update length in fast cycles, captured during reset |
| phase_in | input | 16 | Input phase sample, full scale ±π |
| ref_phase | output | 16 | Reference phase estimate |
| err_sample | output | 32 | Dumped error sample |
| dump_stb | output | 1 | One-cycle strobe marking a new error sample |

## Verification
The bench targets the edge of the update interval. A design that refreshes the reference one cycle too early would make the first sample after a dump use the new phase, and every later sum would then drift away from the model. Length 1 and length 0 are exercised, so an off-by-one in the dump counter or a stuck strobe shows up as the wrong dump spacing. Wrapped errors near ±π and all four sine quadrants are driven, so a wrong mirror or sign in the table shows up in the sums. Carrier runs catch a previous-frequency register that is not kept, or a halving that truncates the wrong bit.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
  // Quarter-wave sine, rational approximation, idx in 0..q
  function automatic int sine_quarter(input int idx, input int q, input int amp);
    longint p;
    longint num;
    longint den;
    p   = longint'(idx) * longint'(2 * q - idx);
    num = longint'(amp) * 4 * p;
    den = 5 * longint'(q) * longint'(q) - p;
    return int'(num / den);
  endfunction
endpackage

// File: rtl/dpll_detector.sv
module dpll_detector #(
  parameter int PHASE_W = 16,
  parameter int LUT_AW  = 6
) (
  input  logic                      sine_sel,
  input  logic [PHASE_W-1:0]        err,
  output logic signed [PHASE_W-1:0] det
);
  localparam int Q     = 1 << LUT_AW;
  localparam int IDX_W = LUT_AW + 1;
  localparam int AMP   = (1 << (PHASE_W - 1)) - 1;

  logic signed [PHASE_W-1:0] tab [0:Q];

  for (genvar g = 0; g <= Q; g++) begin : g_tab
    assign tab[g] = PHASE_W'(dpll_pkg::sine_quarter(g, Q, AMP));
  end

  logic [1:0]                quad;
  logic [LUT_AW-1:0]         k;
  logic [IDX_W-1:0]          idx;
  logic signed [PHASE_W-1:0] mag;
  logic signed [PHASE_W-1:0] sin_v;

  always_comb begin
    quad  = err[PHASE_W-1 -: 2];
    k     = err[PHASE_W-3 -: LUT_AW];
    idx   = quad[0] ? (IDX_W'(Q) - {1'b0, k}) : {1'b0, k};
    mag   = tab[idx];
    sin_v = quad[1] ? -mag : mag;
    det   = sine_sel ? sin_v : $signed(err);
  end
endmodule

// File: rtl/dpll_integrator.sv
module dpll_integrator #(
  parameter int PHASE_W = 16,
  parameter int LEN_W   = 16,
  parameter int ACC_W   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [LEN_W-1:0]          len,
  input  logic signed [PHASE_W-1:0] det,
  output logic signed [ACC_W-1:0]   err_sample,
  output logic                      dump_stb
);
  logic [LEN_W-1:0]        cnt_q, cnt_d, len_m1;
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum, smp_q;
  logic                    last, stb_q;

  always_comb begin
    len_m1  = (len == '0) ? '0 : len - 1'b1;
    last    = (cnt_q == len_m1);
    acc_sum = acc_q + {{(ACC_W-PHASE_W){det[PHASE_W-1]}}, det};
    cnt_d   = last ? '0 : cnt_q + 1'b1;
    acc_d   = last ? '0 : acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
      smp_q <= '0;
      stb_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      stb_q <= last;
      if (last) smp_q <= acc_sum;
    end
  end

  assign err_sample = smp_q;
  assign dump_stb   = stb_q;
endmodule

// File: rtl/dpll_loop_ctrl.sv
module dpll_loop_ctrl #(
  parameter int PHASE_W = 16,
  parameter int ACC_W   = 32,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    carrier,
  input  logic [SHIFT_W-1:0]      shift,
  input  logic signed [ACC_W-1:0] err_sample,
  output logic [PHASE_W-1:0]      ref_phase
);
  logic signed [ACC_W-1:0] y, fp_q;
  logic signed [ACC_W:0]   tsum;
  logic [PHASE_W-1:0]      inc, ref_q, ref_d;

  always_comb begin
    y     = err_sample >>> shift;
    tsum  = {y[ACC_W-1], y} + {fp_q[ACC_W-1], fp_q};
    inc   = carrier ? tsum[PHASE_W:1] : y[PHASE_W-1:0];
    ref_d = ref_q + inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      fp_q  <= '0;
    end else if (upd) begin
      ref_q <= ref_d;
      fp_q  <= y;
    end
  end

  assign ref_phase = ref_q;
endmodule

// File: rtl/dpll_dual_rate.sv
module dpll_dual_rate #(
  parameter int PHASE_W = 16,
  parameter int LEN_W   = 16,
  parameter int SHIFT_W = 4,
  parameter int LUT_AW  = 6,
  localparam int ACC_W  = PHASE_W + LEN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sine_law,
  input  logic               carrier_mode,
  input  logic [SHIFT_W-1:0] gain_shift,
  input  logic [LEN_W-1:0]   upd_len,
  input  logic [PHASE_W-1:0] phase_in,
  output logic [PHASE_W-1:0] ref_phase,
  output logic [ACC_W-1:0]   err_sample,
  output logic               dump_stb
);
  logic [1:0]                sync_q;
  logic                      rst_sync_n;
  logic [LEN_W-1:0]          len_q;
  logic [PHASE_W-1:0]        err;
  logic signed [PHASE_W-1:0] det;
  logic signed [ACC_W-1:0]   smp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_ff @(posedge clk) begin
    if (!rst_sync_n) len_q <= upd_len;
  end

  assign err = phase_in - ref_phase;

  dpll_detector #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW)) u_det (
    .sine_sel (sine_law),
    .err      (err),
    .det      (det)
  );

  dpll_integrator #(.PHASE_W(PHASE_W), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_iad (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .len        (len_q),
    .det        (det),
    .err_sample (smp),
    .dump_stb   (dump_stb)
  );

  dpll_loop_ctrl #(.PHASE_W(PHASE_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .upd        (dump_stb),
    .carrier    (carrier_mode),
    .shift      (gain_shift),
    .err_sample (smp),
    .ref_phase  (ref_phase)
  );

  assign err_sample = smp;
endmodule

// File: rtl/dpll_dual_rate_chk.sv
module dpll_dual_rate_chk #(
  parameter int PHASE_W = 16,
  parameter int LEN_W   = 16,
  parameter int ACC_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dump_stb,
  input logic               carrier_mode,
  input logic [PHASE_W-1:0] ref_phase,
  input logic [ACC_W-1:0]   err_sample,
  input logic [LEN_W-1:0]   len
);
  logic [LEN_W:0] gap_q;
  logic           seen_q;
  logic [LEN_W:0] eff_m1;

  assign eff_m1 = (len == '0) ? '0 : {1'b0, len} - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (dump_stb) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R5
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_stb |=> $stable(ref_phase));

  // R4
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dump_stb |-> $stable(err_sample));

  // R4
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_stb && len > 1) |=> !dump_stb);

  // R4
  dump_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_stb && seen_q) |-> gap_q == eff_m1);

  // R7
  epoch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_stb && !carrier_mode && err_sample == '0) |=> $stable(ref_phase));
endmodule

bind dpll_dual_rate dpll_dual_rate_chk #(.PHASE_W(PHASE_W), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .dump_stb     (dump_stb),
  .carrier_mode (carrier_mode),
  .ref_phase    (ref_phase),
  .err_sample   (err_sample),
  .len          (len_q)
);

// File: tb/dpll_dual_rate_tb.sv
`timescale 1ns/1ps
module dpll_dual_rate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sine_law = 1'b0;
  logic        carrier_mode = 1'b0;
  logic [3:0]  gain_shift = 4'd0;
  logic [15:0] upd_len = 16'd16;
  logic [15:0] phase_in = 16'd0;
  logic [15:0] ref_phase;
  logic [31:0] err_sample;
  logic        dump_stb;

  always #2 clk = ~clk;

  dpll_dual_rate u_dut (
    .clk(clk), .rst_n(rst_n), .sine_law(sine_law), .carrier_mode(carrier_mode),
    .gain_shift(gain_shift), .upd_len(upd_len), .phase_in(phase_in),
    .ref_phase(ref_phase), .err_sample(err_sample), .dump_stb(dump_stb)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct { int smp; logic [15:0] rf; } exp_t;
  exp_t sb_q[$];

  // driver-side model state
  logic [15:0] m_ref, m_pref;
  int m_acc, m_cnt, m_fp, m_pfp, eff_len;
  bit m_pend;

  // monitor state
  bit mon_en = 1'b0;
  bit ref_due, seen;
  logic [15:0] exp_ref, last_ref;
  int gap;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sine_ref(input logic [15:0] e);
    int k, idx, p, v;
    k   = int'(e[13:8]);
    idx = e[14] ? 64 - k : k;
    p   = idx * (128 - idx);
    v   = (32767 * 4 * p) / (5 * 4096 - p);
    return e[15] ? -v : v;
  endfunction

  function automatic int detect(input logic [15:0] e);
    if (sine_law) return sine_ref(e);     // R3
    return int'($signed(e));              // R2
  endfunction

  task automatic drive(input logic [15:0] p);
    logic [15:0] e;
    int d, y;
    longint s;
    @(negedge clk);
    phase_in = p;
    e = p - m_ref;
    d = detect(e);
    if (m_pend) begin
      m_ref  = m_pref;
      m_fp   = m_pfp;
      m_pend = 1'b0;
    end
    m_acc += d;
    m_cnt++;
    if (m_cnt == eff_len) begin
      exp_t it;
      y = m_acc >>> gain_shift;           // R6
      if (carrier_mode) begin             // R8
        s = longint'(y) + longint'(m_fp);
        m_pref = m_ref + 16'(s >>> 1);
      end else begin                      // R7
        m_pref = m_ref + 16'(y);
      end
      m_pfp  = y;
      m_pend = 1'b1;
      it.smp = m_acc;
      it.rf  = m_pref;
      sb_q.push_back(it);
      m_acc = 0;
      m_cnt = 0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (ref_due) begin
        check(ref_phase == exp_ref, "R5/R7/R8 ref after update", ref_phase, exp_ref);
        ref_due = 1'b0;
      end else begin
        check(ref_phase == last_ref, "R5 ref held", ref_phase, last_ref);
      end
      last_ref = ref_phase;
      if (dump_stb) begin
        if (seen) check(gap == eff_len, "R4 dump spacing", gap, eff_len);
        seen = 1'b1;
        gap  = 1;
        if (sb_q.size() == 0) begin
          check(1'b0, "R4 unexpected dump", 1, 0);
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check($signed(err_sample) == it.smp, "R4 error sample", $signed(err_sample), it.smp);
          exp_ref = it.rf;
          ref_due = 1'b1;
        end
      end else begin
        gap++;
      end
    end
  end

  task automatic start(input bit sn, input bit cm, input logic [3:0] sh, input logic [15:0] ln);
    mon_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    sine_law = sn; carrier_mode = cm; gain_shift = sh; upd_len = ln;
    repeat (4) @(negedge clk);
    check(ref_phase == 16'd0, "R1 reset ref", ref_phase, 0);
    check(err_sample == 32'd0, "R1 reset sample", err_sample, 0);
    check(dump_stb == 1'b0, "R1 reset strobe", dump_stb, 0);
    eff_len = (ln == 16'd0) ? 1 : int'(ln);
    m_ref = '0; m_pref = '0; m_acc = 0; m_cnt = 0; m_fp = 0; m_pfp = 0; m_pend = 1'b0;
    sb_q.delete();
    ref_due = 1'b0; seen = 1'b0; gap = 0; last_ref = '0;
    rst_n = 1'b1;
    @(negedge clk);
    mon_en = 1'b1;
  endtask

  initial begin
    logic [15:0] p;
    // sawtooth, epoch summer, constant then wrapped input (R2, R7)
    start(1'b0, 1'b0, 4'd5, 16'd16);
    for (int i = 0; i < 480; i++) drive(16'h2000);
    check((ref_phase > 16'h1FF0) && (ref_phase < 16'h2010), "R7 settles on input", ref_phase, 16'h2000);
    for (int i = 0; i < 160; i++) drive(16'h9000);
    // sawtooth epoch with a phase ramp
    start(1'b0, 1'b0, 4'd3, 16'd8);
    p = 16'h7F00;
    for (int i = 0; i < 300; i++) begin drive(p); p = p + 16'd37; end
    // sine law, epoch, all quadrants (R3)
    start(1'b1, 1'b0, 4'd6, 16'd16);
    for (int i = 0; i < 160; i++) drive(16'h5000);
    for (int i = 0; i < 160; i++) drive(16'hC000);
    for (int i = 0; i < 160; i++) drive(16'h8100);
    // sawtooth, carrier integrator (R8)
    start(1'b0, 1'b1, 4'd7, 16'd16);
    for (int i = 0; i < 400; i++) drive(16'h3000);
    // sine, carrier, ramp
    start(1'b1, 1'b1, 4'd8, 16'd32);
    p = 16'h0000;
    for (int i = 0; i < 640; i++) begin drive(p); p = p - 16'd11; end
    // update length one (R4)
    start(1'b0, 1'b0, 4'd2, 16'd1);
    for (int i = 0; i < 60; i++) drive(16'h1000);
    // update length zero acts as one (R4)
    start(1'b0, 1'b1, 4'd3, 16'd0);
    for (int i = 0; i < 60; i++) drive(16'hE800);
    // zero shift, sine near +pi (R6)
    start(1'b1, 1'b0, 4'd0, 16'd4);
    for (int i = 0; i < 80; i++) drive(16'h7F00);
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule